// File: doc/BRIEF.md
# Serial Two-Wire Target with Busy-Gated Addressing

This block is the byte-level front end of a small peripheral on a two-wire I2C bus. It watches clock and data lines that a faster system clock has already synchronised. From them it picks out the frame markers and clocks in the target address. It acknowledges data bytes and passes each received byte up to a command layer. The command layer is told whether that byte was the first of the frame. The block drives the data line only through an open-drain pull-down enable.

The address byte has no direction bit. Its upper nibble is a fixed pattern and its lower nibble must match four strap pins. When the command layer has decoded an instruction that asks for data, it raises a read-mode input. From the next byte boundary on, the block shifts out bytes that the command layer supplies. A busy input makes the block ignore its own address, so a host can poll by addressing it until it answers. The command layer can also turn away a single data byte by asking for a NACK.

Top module: `i2cb_slave`

## Requirements
- R1: After reset, the block ignores all bus activity until a START has been seen: no acknowledge and no received-byte pulse.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle. It releases SDA and drops any partly received byte. Later bytes are ignored until the next START.
- R3: The address byte is received MSB first. If its bits 7..4 equal 0101 and its bits 3..0 equal `dev_addr_i`, the block pulls SDA low for the whole ninth SCL clock.
- R4: If the address does not match, the block does not acknowledge it. It also neither acknowledges nor reports any further byte until the next START.
- R5: While `busy_i` is high at the SCL falling edge that ends the eighth address bit, even a matching address is not acknowledged.
- R6: In write direction, `rx_valid_o` pulses for one cycle after the eighth rising SCL edge of each data byte. At that point `rx_data_o` holds the byte (first bit received in bit 7). `rx_first_o` is 1 for the first data byte after the address and 0 for every later byte.
- R7: Each received data byte is acknowledged on its ninth clock, unless `rx_refuse_i` is high at the SCL falling edge that ends the eighth bit. In that case SDA stays released (NACK).
- R8: `read_mode_i` is sampled at the SCL falling edge that ends an acknowledge slot. If it is high, the block loads `tx_data_i` and pulses `tx_load_o`. It then sends the byte bit 7 first, pulling SDA low for each 0 bit, and releases SDA for the ninth clock.
- R9: In read direction, a master ACK (SDA low on the ninth rising edge) loads and sends the next byte. A NACK leaves SDA released, with no more loads and no driving until the next START.
- R10: A repeated START in the middle of any byte returns the block to address reception, and the next data byte is again flagged as first.
- R11: The SDA pull-down enable changes only while SCL is low.
- R12: During and right after reset, SDA is released and neither `rx_valid_o` nor `tx_load_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| dev_addr_i | input | 4 | Strap pins compared with the low address nibble |
| busy_i | input | 1 | Suppresses address acknowledge while high |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle pulse per received data byte |
| rx_first_o | output | 1 | Byte was the first after the address |
| rx_refuse_i | input | 1 | Ask for NACK on the current received byte |
| read_mode_i | input | 1 | Next byte is sent by the block |
| tx_data_i | input | 8 | Byte to send, captured on `tx_load_o` |
| tx_load_o | output | 1 | One-cycle pulse when `tx_data_i` is captured |

## Verification
The bench aims at the address decision. It covers a wrong prefix, a wrong strap nibble and a matching address while busy. A design that compares only part of the byte, or samples busy at the wrong moment, would acknowledge a poll it should ignore, or would keep taking data after a failed match. It also runs a repeated START in mid-byte and a STOP in mid-address. A block that kept its bit count across those markers would frame the next address wrongly and miss the acknowledge. In read direction it checks that a master NACK really silences the block: a design that kept shifting would pull SDA low on the following clocks and call for one load too many.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_HOLD
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              first;
        logic              mack;
        logic              rxv;
        logic [BYTE_W-1:0] rxd;
        logic              rxf;
        logic              txl;
    } core_t;
endpackage

// File: rtl/i2cb_bus_events.sv
module i2cb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    // markers only count when SCL was and still is high
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cb_addr_match.sv
module i2cb_addr_match #(
    parameter int          PIN_W  = 4,
    parameter int          PFX_W  = 4,
    parameter logic [PFX_W-1:0] PREFIX = 4'b0101,
    localparam int         ADDR_W = PIN_W + PFX_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PIN_W-1:0]  pins_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] want;
    logic [ADDR_W-1:0] same;

    assign want = {PREFIX, pins_i};

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign same[i] = ~(addr_i[i] ^ want[i]);
    end

    assign hit_o = &same;
endmodule

// File: rtl/i2cb_slave.sv
module i2cb_slave
    import i2cb_pkg::*;
#(
    parameter int PIN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [PIN_W-1:0]  dev_addr_i,
    input  logic              busy_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              rx_first_o,
    input  logic              rx_refuse_i,
    input  logic              read_mode_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              tx_load_o
);
    localparam int PFX_W = BYTE_W - PIN_W;

    logic  scl_rise, scl_fall, bus_start, bus_stop, addr_hit;
    core_t q, d;

    i2cb_bus_events u_ev (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (bus_start),
        .stop_o    (bus_stop)
    );

    i2cb_addr_match #(
        .PIN_W (PIN_W),
        .PFX_W (PFX_W),
        .PREFIX(PFX_W'(4'b0101))
    ) u_match (
        .addr_i(q.sh),
        .pins_i(dev_addr_i),
        .hit_o (addr_hit)
    );

    always_comb begin
        d     = q;
        d.rxv = 1'b0;
        d.txl = 1'b0;
        if (bus_start) begin
            d.st    = ST_ADDR;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.first = 1'b1;
        end else if (bus_stop) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (addr_hit && !busy_i) begin
                            d.oe = 1'b1;
                            d.st = ST_AACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK, ST_RACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (read_mode_i) begin
                            d.st  = ST_TX;
                            d.sh  = tx_data_i;
                            d.oe  = ~tx_data_i[BYTE_W-1];
                            d.txl = 1'b1;
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT - 1'b1) begin
                            d.rxv = 1'b1;
                            d.rxd = {q.sh[BYTE_W-2:0], sda_i};
                            d.rxf = q.first;
                        end
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.oe    = ~rx_refuse_i;
                        d.st    = ST_RACK;
                        d.first = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_TACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.sh  = tx_data_i;
                            d.oe  = ~tx_data_i[BYTE_W-1];
                            d.txl = 1'b1;
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign rx_data_o  = q.rxd;
    assign rx_valid_o = q.rxv;
    assign rx_first_o = q.rxf;
    assign tx_load_o  = q.txl;
endmodule

// File: rtl/i2cb_slave_chk.sv
module i2cb_slave_chk
    import i2cb_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic busy_i,
    input logic rx_valid_o,
    input logic tx_load_o,
    input st_e  st
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);  // R11

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK && $past(st) != ST_AACK) |-> !$past(busy_i));  // R5

    AST_ADDR_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_AACK) |-> sda_oe_o);  // R3

    AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);  // R6

    AST_LOAD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> st == ST_TX);  // R8

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_HOLD) |-> !sda_oe_o);  // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!sda_oe_o && !rx_valid_o && !tx_load_o));  // R12
endmodule

bind i2cb_slave i2cb_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .busy_i    (busy_i),
    .rx_valid_o(rx_valid_o),
    .tx_load_o (tx_load_o),
    .st        (q.st)
);

// File: tb/i2cb_slave_tb.sv
module i2cb_slave_tb;
    localparam int Q = 10;
    localparam logic [3:0] PINS = 4'b1010;
    // {address byte, busy, expected ack}
    localparam logic [9:0] VEC [6] = '{
        {8'h5A, 1'b0, 1'b1},
        {8'h5B, 1'b0, 1'b0},
        {8'h4A, 1'b0, 1'b0},
        {8'h5A, 1'b1, 1'b0},
        {8'hDA, 1'b0, 1'b0},
        {8'h5A, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic busy = 1'b0, refuse = 1'b0, rmode = 1'b0;
    logic [7:0] txd = 8'h00;
    logic oe, rxv, rxf, txl;
    logic [7:0] rxd;
    wire sda_line = sda_m & ~oe;

    int total = 0, bad = 0, rx_n = 0, tx_n = 0, viol = 0;
    logic [7:0] rx_last = 8'h00;
    logic rx_lf = 1'b0, oe_prev = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    i2cb_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(oe), .dev_addr_i(PINS), .busy_i(busy),
        .rx_data_o(rxd), .rx_valid_o(rxv), .rx_first_o(rxf),
        .rx_refuse_i(refuse), .read_mode_i(rmode),
        .tx_data_i(txd), .tx_load_o(txl)
    );

    always @(negedge clk) begin
        if (rxv) begin rx_n++; rx_last = rxd; rx_lf = rxf; end
        if (txl) tx_n++;
        if (rst_n && oe != oe_prev && scl) viol++;
        oe_prev = oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        scl = 1'b0; tick(Q); sda_m = b; tick(Q); scl = 1'b1; tick(2*Q);
    endtask

    task automatic bit_in(output logic b);
        scl = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(Q); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send8(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic ack_slot(output logic a);
        logic b;
        bit_in(b);
        a = ~b;
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic a);
        send8(v);
        ack_slot(a);
    endtask

    task automatic rd8(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        int n0, t0;
        tick(5);
        chk("R12 oe during reset", oe, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R12 oe after reset", oe, 0);
        chk("R12 no rx pulse", rx_n, 0);
        chk("R12 no tx load", tx_n, 0);

        // R1: no START yet
        wr_byte(8'h5A, a);
        chk("R1 no ack before start", a, 0);
        wr_byte(8'h11, a);
        chk("R1 no rx before start", rx_n, 0);

        // R3 R4 R5 vector walk
        for (int i = 0; i < 6; i++) begin
            busy = VEC[i][1];
            bus_start();
            wr_byte(VEC[i][9:2], a);
            chk($sformatf("R3 R4 R5 addr ack vec%0d", i), a, VEC[i][0]);
            busy = 1'b0;
            n0 = rx_n;
            wr_byte(8'h3C, a);
            chk($sformatf("R4 R7 data ack vec%0d", i), a, VEC[i][0]);
            chk($sformatf("R4 R6 rx count vec%0d", i), rx_n - n0, VEC[i][0]);
            bus_stop();
        end

        // R6 R7 multi-byte write, then refusal
        bus_start();
        wr_byte(8'h5A, a);
        wr_byte(8'h11, a);
        chk("R6 first data", rx_last, 8'h11);
        chk("R6 first flag set", rx_lf, 1);
        chk("R7 ack first", a, 1);
        wr_byte(8'h22, a);
        chk("R6 second data", rx_last, 8'h22);
        chk("R6 first flag clear", rx_lf, 0);
        refuse = 1'b1;
        n0 = rx_n;
        wr_byte(8'h42, a);
        refuse = 1'b0;
        chk("R7 refused byte nack", a, 0);
        chk("R7 refused byte still reported", rx_n - n0, 1);
        chk("R7 refused byte data", rx_last, 8'h42);
        bus_stop();

        // R8 R9 read sequence
        t0 = tx_n;
        bus_start();
        wr_byte(8'h5A, a);
        send8(8'h80);
        rmode = 1'b1;
        txd = 8'hA5;
        ack_slot(a);
        chk("R7 instruction ack", a, 1);
        rd8(v);
        chk("R8 first read byte", v, 8'hA5);
        chk("R8 one load", tx_n - t0, 1);
        txd = 8'h3C;
        bit_out(1'b0);
        rd8(v);
        chk("R9 byte after ack", v, 8'h3C);
        bit_out(1'b1);
        rd8(v);
        chk("R9 silent after nack", v, 8'hFF);
        chk("R9 no load after nack", tx_n - t0, 2);
        bus_stop();
        rmode = 1'b0;

        // R10 repeated START mid-byte
        bus_start();
        wr_byte(8'h5A, a);
        wr_byte(8'h01, a);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        wr_byte(8'h5A, a);
        chk("R10 address ack after restart", a, 1);
        wr_byte(8'h66, a);
        chk("R10 data after restart", rx_last, 8'h66);
        chk("R10 first flag after restart", rx_lf, 1);
        bus_stop();

        // R2 STOP in mid-address
        bus_start();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        n0 = rx_n;
        wr_byte(8'h5A, a);
        chk("R2 no ack after stop", a, 0);
        wr_byte(8'h77, a);
        chk("R2 no rx after stop", rx_n - n0, 0);
        chk("R2 released after stop", oe, 0);

        chk("R11 oe change with scl high", viol, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule